// File: doc/BRIEF.md
# Layer Activation Requantizer

This block converts one layer's worth of wide signed accumulator results into narrow unsigned activations. A vector of `NUM_LANES` signed 32-bit values enters together under a single valid strobe. Every lane first has a rectifier applied, so negative values become zero. A balanced comparator tree, one registered level per halving, then finds the largest rectified value in the vector. A five-step binary search locates the highest set bit of that maximum. From that bit position a single right-shift amount is chosen for the whole layer. Each lane keeps only the eight bits that start at that shift, so the rescaling costs a shift and a truncation rather than a divider.

The shifted 8-bit lanes come out together with the shift amount. Downstream logic can therefore track the scale factor of every layer. The pipeline accepts a new vector on every cycle. Output valid trails input valid by a fixed number of cycles that depends only on the lane count.

Top module: `layerRequant`

## Requirements
- R1: While and after reset, and before any vector has been accepted, `outValid` is 0, `outData` is all zero and `outShift` is 0.
- R2: Each vector accepted with `inValid` high produces exactly one cycle of `outValid` exactly log2(NUM_LANES)+3 clock cycles later (6 for 8 lanes). Vectors may arrive on consecutive cycles.
- R3: A lane whose bit 31 is set (negative) is treated as zero. It yields output 0 and cannot become the layer maximum.
- R4: With p the index of the highest set bit of the layer maximum after rectification and p >= 7, `outShift` equals p-7, which never exceeds 23. The lane holding the maximum then has output bit 7 set.
- R5: When the layer maximum is non-zero but below 128 (p < 7), `outShift` is 0 and every rectified lane passes through unchanged.
- R6: When every lane is zero or negative, every output lane is 0 and `outShift` is 0.
- R7: Each output lane equals bits [outShift+7 : outShift] of its rectified input. Lower bits are discarded with no rounding.
- R8: Input lane j occupies `inData` bits [32j+31 : 32j], and its result appears on `outData` bits [8j+7 : 8j].
- R9: While `outValid` is low, `outData` and `outShift` hold the previous result. Values on `inData` while `inValid` is low have no effect.
- R10: The maximum is found wherever it sits among the lanes, including when several lanes tie.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Marks `inData` as a vector to process this cycle |
| inData | input | NUM_LANES*32 | Signed accumulator lanes, lane 0 in the low bits |
| outValid | output | 1 | One-cycle strobe marking a new result |
| outData | output | NUM_LANES*8 | Unsigned 8-bit activations, lane 0 in the low bits |
| outShift | output | 5 | Right-shift applied to this layer's lanes |

## Verification
The main sweep places a maximum with its leading one at every bit position from 0 to 30, in every lane position. The other lanes are filled with smaller positives, ties and negatives. This separates a wrong shift choice, an off-by-one truncation window, a comparator that misses some tree positions and a rectifier that lets negatives win. Hand-picked vectors cover the all-negative and all-zero layers, the largest positive value, equal lanes at the 127/128/256 thresholds and a distinct value per lane to expose swapped lanes. Runs of back-to-back vectors, interleaved with idle cycles that carry junk data, check the fixed latency and the holding of outputs between results.

// File: rtl/reqPkg.sv
package reqPkg;

  // Strobes passed from the control sequencer to the datapath.
  typedef struct packed {
    logic captureIn;  // register rectified lanes from the input
    logic searchEn;   // register leading-one shift and aligned lanes
    logic emitEn;     // register truncated lanes and shift onto outputs
  } reqStrobes_t;

endpackage

// File: rtl/reqCtrl.sv
module reqCtrl
  import reqPkg::*;
#(
  parameter int TREE_DEPTH = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output reqStrobes_t strobes,
  output logic        outValid
);

  localparam int STAGES = TREE_DEPTH + 3;

  // validPipe[k] is high when stage k holds a live vector
  logic [STAGES-1:0] validPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validPipe <= '0;
    end else begin
      validPipe <= {validPipe[STAGES-2:0], inValid};
    end
  end

  always_comb begin
    strobes.captureIn = inValid;
    strobes.searchEn  = validPipe[TREE_DEPTH];
    strobes.emitEn    = validPipe[TREE_DEPTH+1];
  end

  assign outValid = validPipe[STAGES-1];

endmodule

// File: rtl/reqMaxTree.sv
module reqMaxTree #(
  parameter int LANES = 8,
  parameter int W     = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [LANES*W-1:0] leaves,
  output logic [W-1:0]       maxOut
);

  // Heap-ordered nodes: node 1 is the root, children of k are 2k and 2k+1.
  // Indices at or above LANES refer to the leaf lanes.
  logic [W-1:0] node  [1:LANES-1];
  logic [W-1:0] leftV [1:LANES-1];
  logic [W-1:0] rightV[1:LANES-1];

  always_comb begin
    for (int k = 1; k < LANES; k++) begin
      if (2 * k >= LANES) begin
        leftV[k]  = leaves[(2*k - LANES) * W +: W];
        rightV[k] = leaves[(2*k + 1 - LANES) * W +: W];
      end else begin
        leftV[k]  = node[2*k];
        rightV[k] = node[2*k + 1];
      end
    end
  end

  // One register per node: each tree level adds one cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 1; k < LANES; k++) node[k] <= '0;
    end else begin
      for (int k = 1; k < LANES; k++)
        node[k] <= (leftV[k] > rightV[k]) ? leftV[k] : rightV[k];
    end
  end

  assign maxOut = node[1];

endmodule

// File: rtl/reqLeadOne.sv
module reqLeadOne #(
  parameter int W     = 32,
  parameter int OUT_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 loadEn,
  input  logic [W-1:0]         value,
  output logic [$clog2(W)-1:0] shiftOut
);

  localparam int SHW = $clog2(W);

  // Binary search for the highest set bit: each step halves the window.
  function automatic logic [SHW-1:0] topBit(input logic [W-1:0] x);
    logic [W-1:0]   rem;
    logic [SHW-1:0] pos;
    rem = x;
    pos = '0;
    for (int s = SHW - 1; s >= 0; s--) begin
      if ((rem >> (1 << s)) != '0) begin
        pos = pos + SHW'(1 << s);
        rem = rem >> (1 << s);
      end
    end
    return pos;
  endfunction

  logic [SHW-1:0] topPos;
  logic [SHW-1:0] shiftNext;

  always_comb begin
    topPos = topBit(value);
    if (value == '0 || topPos < SHW'(OUT_W - 1)) shiftNext = '0;
    else shiftNext = topPos - SHW'(OUT_W - 1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftOut <= '0;
    else if (loadEn) shiftOut <= shiftNext;
  end

endmodule

// File: rtl/reqDatapath.sv
module reqDatapath
  import reqPkg::*;
#(
  parameter int NUM_LANES = 8,
  parameter int IN_W      = 32,
  parameter int OUT_W     = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  reqStrobes_t                strobes,
  input  logic [NUM_LANES*IN_W-1:0]  inData,
  output logic [NUM_LANES*OUT_W-1:0] outData,
  output logic [$clog2(IN_W)-1:0]    outShift
);

  localparam int TREE_DEPTH = $clog2(NUM_LANES);
  localparam int SHW        = $clog2(IN_W);
  localparam int VEC_W      = NUM_LANES * IN_W;

  logic [VEC_W-1:0]           reluNext;
  logic [VEC_W-1:0]           reluQ;
  logic [VEC_W-1:0]           lanePipe [1:TREE_DEPTH];
  logic [VEC_W-1:0]           alignedQ;
  logic [IN_W-1:0]            layerMax;
  logic [SHW-1:0]             shiftQ;
  logic [NUM_LANES*OUT_W-1:0] truncNext;

  // Rectifier per lane
  for (genvar j = 0; j < NUM_LANES; j++) begin : gRelu
    assign reluNext[j*IN_W +: IN_W] =
      inData[j*IN_W + IN_W - 1] ? '0 : inData[j*IN_W +: IN_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) reluQ <= '0;
    else if (strobes.captureIn) reluQ <= reluNext;
  end

  reqMaxTree #(
    .LANES (NUM_LANES),
    .W     (IN_W)
  ) uTree (
    .clk    (clk),
    .rstN   (rstN),
    .leaves (reluQ),
    .maxOut (layerMax)
  );

  // Lanes ride alongside the comparator tree, one register per tree level.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int t = 1; t <= TREE_DEPTH; t++) lanePipe[t] <= '0;
    end else begin
      lanePipe[1] <= reluQ;
      for (int t = 2; t <= TREE_DEPTH; t++) lanePipe[t] <= lanePipe[t-1];
    end
  end

  reqLeadOne #(
    .W     (IN_W),
    .OUT_W (OUT_W)
  ) uLead (
    .clk      (clk),
    .rstN     (rstN),
    .loadEn   (strobes.searchEn),
    .value    (layerMax),
    .shiftOut (shiftQ)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) alignedQ <= '0;
    else if (strobes.searchEn) alignedQ <= lanePipe[TREE_DEPTH];
  end

  // Keep the OUT_W-bit window starting at the chosen shift
  for (genvar j = 0; j < NUM_LANES; j++) begin : gTrunc
    assign truncNext[j*OUT_W +: OUT_W] =
      OUT_W'(alignedQ[j*IN_W +: IN_W] >> shiftQ);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outData  <= '0;
      outShift <= '0;
    end else if (strobes.emitEn) begin
      outData  <= truncNext;
      outShift <= shiftQ;
    end
  end

endmodule

// File: rtl/layerRequant.sv
module layerRequant
  import reqPkg::*;
#(
  parameter int NUM_LANES = 8,
  parameter int IN_W      = 32,
  parameter int OUT_W     = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       inValid,
  input  logic [NUM_LANES*IN_W-1:0]  inData,
  output logic                       outValid,
  output logic [NUM_LANES*OUT_W-1:0] outData,
  output logic [$clog2(IN_W)-1:0]    outShift
);

  localparam int TREE_DEPTH = $clog2(NUM_LANES);

  reqStrobes_t strobes;

  reqCtrl #(
    .TREE_DEPTH (TREE_DEPTH)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobes  (strobes),
    .outValid (outValid)
  );

  reqDatapath #(
    .NUM_LANES (NUM_LANES),
    .IN_W      (IN_W),
    .OUT_W     (OUT_W)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .inData   (inData),
    .outData  (outData),
    .outShift (outShift)
  );

endmodule

// File: rtl/reqChecker.sv
module reqChecker #(
  parameter int NUM_LANES = 8,
  parameter int IN_W      = 32,
  parameter int OUT_W     = 8
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       inValid,
  input logic                       outValid,
  input logic [NUM_LANES*OUT_W-1:0] outData,
  input logic [$clog2(IN_W)-1:0]    outShift
);

  localparam int LAT = $clog2(NUM_LANES) + 3;

  logic [LAT-1:0]       validHist;
  logic [NUM_LANES-1:0] laneTop;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validHist <= '0;
    else validHist <= {validHist[LAT-2:0], inValid};
  end

  for (genvar j = 0; j < NUM_LANES; j++) begin : gTop
    assign laneTop[j] = outData[j*OUT_W + OUT_W - 1];
  end

  // R2: output strobe trails the input strobe by the fixed latency
  a_r2_valid_latency: assert property (@(posedge clk) disable iff (!rstN)
    outValid == validHist[LAT-1]);

  // R9: results hold between strobes
  a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> ($stable(outData) && $stable(outShift)));

  // R4: shift never exceeds the width gap
  a_r4_shift_range: assert property (@(posedge clk) disable iff (!rstN)
    int'(outShift) <= IN_W - 1 - OUT_W);

  // R4: a non-zero shift puts the maximum's leading one on the top output bit
  a_r4_top_bit_set: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outShift != '0) |-> (laneTop != '0));

  // R6: an all-zero result never carries a shift
  a_r6_zero_no_shift: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outData == '0) |-> (outShift == '0));

endmodule

bind layerRequant reqChecker #(
  .NUM_LANES (NUM_LANES),
  .IN_W      (IN_W),
  .OUT_W     (OUT_W)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .outValid (outValid),
  .outData  (outData),
  .outShift (outShift)
);

// File: tb/tb_layerRequant.sv
module tb_layerRequant;

  localparam int LANES = 8;
  localparam int IN_W  = 32;
  localparam int OUT_W = 8;
  localparam int SHW   = $clog2(IN_W);
  localparam int LAT   = $clog2(LANES) + 3;

  logic                   clk = 1'b0;
  logic                   rstN = 1'b0;
  logic                   inValid = 1'b0;
  logic [LANES*IN_W-1:0]  inData = '0;
  logic                   outValid;
  logic [LANES*OUT_W-1:0] outData;
  logic [SHW-1:0]         outShift;

  always #5 clk = ~clk;

  layerRequant #(
    .NUM_LANES (LANES),
    .IN_W      (IN_W),
    .OUT_W     (OUT_W)
  ) dut (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inData   (inData),
    .outValid (outValid),
    .outData  (outData),
    .outShift (outShift)
  );

  int     checks = 0;
  int     errors = 0;
  longint cyc = 0;
  bit     monOn = 1'b0;
  bit     haveLast = 1'b0;
  bit     finished = 1'b0;
  logic [LANES*OUT_W-1:0] lastData = '0;
  logic [SHW-1:0]         lastShift = '0;
  logic [31:0]            rng = 32'h2545_f491;

  logic [LANES*OUT_W-1:0] expData [$];
  logic [SHW-1:0]         expShift[$];
  longint                 expStamp[$];
  string                  expTag  [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic nextRand(output logic [31:0] r);
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    r = rng;
  endtask

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] got, input logic [63:0] want);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, want);
    end
  endtask

  // Expected result from the requirements: rectify, take max, find top bit.
  task automatic model(input logic [LANES*IN_W-1:0] vec,
                       output logic [LANES*OUT_W-1:0] d,
                       output logic [SHW-1:0] sh);
    logic [IN_W-1:0] r [LANES];
    logic [IN_W-1:0] mx;
    int top;
    mx = '0;
    for (int j = 0; j < LANES; j++) begin
      r[j] = vec[j*IN_W + IN_W - 1] ? '0 : vec[j*IN_W +: IN_W];
      if (r[j] > mx) mx = r[j];
    end
    top = -1;
    for (int b = 0; b < IN_W; b++) if (mx[b]) top = b;
    sh = (top >= OUT_W - 1) ? SHW'(top - (OUT_W - 1)) : '0;
    for (int j = 0; j < LANES; j++) begin
      logic [IN_W-1:0] s;
      s = r[j] >> sh;
      d[j*OUT_W +: OUT_W] = s[OUT_W-1:0];
    end
  endtask

  // Drive one vector at the current negedge and leave it for one cycle.
  task automatic sendVec(input logic [LANES*IN_W-1:0] vec, input string tag);
    logic [LANES*OUT_W-1:0] d;
    logic [SHW-1:0] sh;
    model(vec, d, sh);
    expData.push_back(d);
    expShift.push_back(sh);
    expStamp.push_back(cyc);
    expTag.push_back(tag);
    inData  = vec;
    inValid = 1'b1;
    @(negedge clk);
  endtask

  task automatic idleJunk(input int n);
    logic [31:0] r;
    for (int i = 0; i < n; i++) begin
      inValid = 1'b0;
      for (int j = 0; j < LANES; j++) begin
        nextRand(r);
        inData[j*IN_W +: IN_W] = r;
      end
      @(negedge clk);
    end
  endtask

  // Monitor: compares every result and checks holding between results.
  always @(negedge clk) begin
    if (monOn && rstN) begin
      if (outValid) begin
        if (expData.size() == 0) begin
          check(1'b0, "R2", "unexpected outValid", 64'(outValid), 64'd0);
        end else begin
          logic [LANES*OUT_W-1:0] d;
          logic [SHW-1:0] sh;
          longint st;
          string tg;
          d  = expData.pop_front();
          sh = expShift.pop_front();
          st = expStamp.pop_front();
          tg = expTag.pop_front();
          check(outData == d, tg, "lanes", 64'(outData), 64'(d));
          check(outShift == sh, tg, "shift", 64'(outShift), 64'(sh));
          check(cyc - st == LAT, "R2", "latency", 64'(cyc - st), 64'(LAT));
        end
        lastData  = outData;
        lastShift = outShift;
        haveLast  = 1'b1;
      end else if (haveLast) begin
        check(outData == lastData && outShift == lastShift, "R9", "hold",
              64'({outShift, outData}), 64'({lastShift, lastData}));
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [LANES*IN_W-1:0] vec;
    logic [31:0] r, r2, maxVal, mask;
    string tg;

    // R1: reset state, with junk applied to the inputs
    inValid = 1'b1;
    inData  = {LANES{32'h0000_7fff}};
    repeat (3) @(negedge clk);
    check(outValid == 1'b0 && outData == '0 && outShift == '0, "R1",
          "in reset", 64'({outValid, outShift, outData}), 64'd0);
    inValid = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0 && outData == '0 && outShift == '0, "R1",
          "after reset", 64'({outValid, outShift, outData}), 64'd0);
    monOn = 1'b1;

    // Sweep: leading one of the maximum at every bit, in every lane (R4 R5 R7 R10)
    for (int p = 0; p <= 30; p++) begin
      for (int m = 0; m < LANES; m++) begin
        mask = (32'h1 << p) - 32'h1;
        nextRand(r);
        maxVal = (32'h1 << p) | (r & mask);
        for (int j = 0; j < LANES; j++) begin
          nextRand(r);
          nextRand(r2);
          if (j == m) vec[j*IN_W +: IN_W] = maxVal;
          else if (r[1:0] == 2'b00) vec[j*IN_W +: IN_W] = {1'b1, r2[30:0]};
          else if (r[1:0] == 2'b01) vec[j*IN_W +: IN_W] = maxVal;
          else begin
            r2 = r2 & ((mask << 1) | 32'h1);
            vec[j*IN_W +: IN_W] = (r2 > maxVal) ? (maxVal >> 1) : r2;
          end
        end
        tg = (p < 7) ? "R5 R7 R10" : "R4 R7 R10";
        sendVec(vec, tg);
        if (((p + m) % 3) == 0) idleJunk(1);
      end
    end
    inValid = 1'b0;
    idleJunk(LAT + 2);

    // R6: all negative, all zero
    sendVec({LANES{32'h8000_0000}}, "R6 R3");
    sendVec('0, "R6");
    // R3: negatives of huge magnitude cannot win
    vec = {LANES{32'hffff_ffff}};
    vec[2*IN_W +: IN_W] = 32'h0000_0300;
    sendVec(vec, "R3 R4");
    // Largest positive value gives the largest shift
    vec = {LANES{32'h8000_0001}};
    vec[7*IN_W +: IN_W] = 32'h7fff_ffff;
    sendVec(vec, "R4");
    // Threshold ties
    sendVec({LANES{32'h0000_007f}}, "R5 R10");
    sendVec({LANES{32'h0000_0080}}, "R4 R10");
    sendVec({LANES{32'h0000_0100}}, "R4 R7 R10");
    // R8: distinct value per lane, maximum in lane 5
    for (int j = 0; j < LANES; j++)
      vec[j*IN_W +: IN_W] = 32'h10 * (j + 1) + ((j == 5) ? 32'h0000_1000 : 32'h0);
    sendVec(vec, "R8");
    for (int j = 0; j < LANES; j++) vec[j*IN_W +: IN_W] = 32'(j + 1);
    sendVec(vec, "R8 R5");
    // R9: long idle stretch with junk on the data input
    idleJunk(20);
    sendVec({LANES{32'h0001_2345}}, "R7");
    idleJunk(LAT + 4);

    check(expData.size() == 0, "R2", "results outstanding",
          64'(expData.size()), 64'd0);
    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule